// File: doc/BRIEF.md
# Synchronous Pipelined Burst SRAM

This block is a single-port synchronous static RAM of 18-bit words with its own burst address generator. All synchronous inputs are taken on the rising clock edge. These are the address, the write data, three chip selects, two competing address-load strobes, a burst-step input and four write-control inputs. A load registers a base address and the selection state. The low two address bits of later beats come from an internal 2-bit beat counter. The counter steps only while the step input is low. Its order is either linear or interleaved, chosen by a static order input that acts without the clock.

Each word is split into two 9-bit lanes, and each lane holds 8 data bits and 1 parity bit. Writes go to one lane, to both lanes, or to neither. A write is registered together with its address and is committed one edge later, with no external strobe timing. In a write cycle the output register receives the merged new word, so the written data passes through to the read port. Read data leaves through an output register and is qualified by a drive-enable flag. The pad driver is outside this block.

There is no valid/ready handshake and no back-pressure. Data comes out at a fixed latency of two clock edges after the address is loaded. The consumer must take each beat in the cycle it is presented, and the only way to hold the port is to keep the step input high. The address width is a parameter: `ADDR_W=16` gives 65536 words, and the default is smaller so that elaboration stays light.

Top module: `sbsram_burst`

## Requirements
- R1: Each word is 18 bits wide. When an address is loaded at clock edge k and the chip is selected, that word appears on `rdata` after edge k+1, with `rdata_oe` high while `oe_n` is low.
- R2: A low `ld_ctl_n` loads `addr` and the selection state at the edge, whatever the level of `cs_n`. A low `ld_cpu_n` together with a low `cs_n` also loads them.
- R3: A low `ld_cpu_n` while `cs_n` is high and `ld_ctl_n` is high is ignored: the loaded address and the selection state stay unchanged.
- R4: A load sets the beat count to 0. Each edge with `step_n` low and the chip selected adds 1 to the count, modulo 4. While `step_n` is high the count, and so the address, holds.
- R5: With `order_lin`=1 the low two address bits are (loaded low bits + beat) mod 4. With `order_lin`=0 they are (loaded low bits XOR beat). Address bits above bit 1 come from the load unchanged.
- R6: The low lane is bits [8:0] and the high lane is bits [17:9]. `wen_lo_n`/`wen_hi_n` low writes that lane only while `wen_gate_n` is low. A low `wen_all_n` writes both lanes whatever the lane enables are.
- R7: Write controls and data are registered with the address, and the write commits at the following edge. Any cycle that `ld_cpu_n` loads is a read, whatever the write controls are.
- R8: After a write cycle, `rdata` shows the merged new word (pass-through), and a following read of that address returns it.
- R9: The chip is selected only if at load `cs_n`=0, `cs_hi`=1 and `cs_lo_n`=0. A deselecting load drops `rdata_oe` after the next edge, which is two edges from the load. `rdata_oe` is low out of reset.
- R10: `oe_n` high forces `rdata_oe` low at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| addr | input | ADDR_W | Word address, taken on a load |
| wdata | input | 18 | Write data, two 9-bit lanes |
| cs_n | input | 1 | Active-low primary chip select |
| cs_hi | input | 1 | Active-high expansion select |
| cs_lo_n | input | 1 | Active-low expansion select |
| ld_cpu_n | input | 1 | Processor-side load strobe, gated by cs_n |
| ld_ctl_n | input | 1 | Controller-side load strobe, always honoured |
| step_n | input | 1 | Burst step, active low |
| wen_lo_n | input | 1 | Low-lane write enable, active low |
| wen_hi_n | input | 1 | High-lane write enable, active low |
| wen_gate_n | input | 1 | Gate for the lane enables, active low |
| wen_all_n | input | 1 | Whole-word write, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| rdata | output | 18 | Output register contents |
| rdata_oe | output | 1 | Drive enable for rdata |

## Verification
The bench sweeps every start offset in both burst orders, and it also writes a burst in interleaved order and reads it back. A counter that wrapped wrongly, or that mixed up addition and XOR, would return a neighbour's word. All sixteen combinations of the four write controls are tried, each followed by a pass-through check and a read-back. A gate that was ignored, or a whole-word override that lost to the lane enables, would corrupt one lane. Further cases check that a processor strobe during a high `cs_n` leaves the burst in place, and that deselection takes exactly two edges and comes from each select pin. A block that loaded the strobe anyway, or that cut the drive one edge early or late, would fail these.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int LANE_BITS = 9;
  localparam int NUM_LANES = 2;
  localparam int WORD_BITS = LANE_BITS * NUM_LANES;

  typedef logic [NUM_LANES-1:0] lane_mask_t;

  typedef enum logic {
    ORDER_XOR = 1'b0,
    ORDER_INC = 1'b1
  } order_e;
endpackage

// File: rtl/sbsram_beat_ctr.sv
module sbsram_beat_ctr
  import sbsram_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  order_e            order,
  input  logic [BEAT_W-1:0] start,
  output logic [BEAT_W-1:0] cur_lo
);
  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      beat_q <= '0;
    else if (load)   beat_q <= '0;
    else if (step)   beat_q <= beat_q + 1'b1;
  end

  always_comb begin
    if (order == ORDER_INC) cur_lo = start + beat_q;
    else                    cur_lo = start ^ beat_q;
  end

  a_r4_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (beat_q == '0));
  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (beat_q == BEAT_W'($past(beat_q) + 1'b1)));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(beat_q));
endmodule

// File: rtl/sbsram_lane_dec.sv
module sbsram_lane_dec
  import sbsram_pkg::*;
(
  input  logic       rd_only,
  input  logic       wen_all_n,
  input  logic       wen_gate_n,
  input  lane_mask_t lane_n,
  output lane_mask_t mask
);
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign mask[i] = !rd_only && (!wen_all_n || (!wen_gate_n && !lane_n[i]));
  end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int AW     = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic [AW-1:0]           addr,
  input  logic [LANES-1:0]        wmask,
  input  logic [LANE_W*LANES-1:0] wdata,
  output logic [LANE_W*LANES-1:0] rd_q
);
  localparam int DW    = LANE_W * LANES;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] old_word;
  logic [DW-1:0] merged;

  assign old_word = mem[addr];

  for (genvar i = 0; i < LANES; i++) begin : g_merge
    assign merged[i*LANE_W +: LANE_W] =
      wmask[i] ? wdata[i*LANE_W +: LANE_W] : old_word[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (|wmask) mem[addr] <= merged;
    rd_q <= merged;
  end
endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BEAT_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_BITS-1:0] wdata,
  input  logic                 cs_n,
  input  logic                 cs_hi,
  input  logic                 cs_lo_n,
  input  logic                 ld_cpu_n,
  input  logic                 ld_ctl_n,
  input  logic                 step_n,
  input  logic                 wen_lo_n,
  input  logic                 wen_hi_n,
  input  logic                 wen_gate_n,
  input  logic                 wen_all_n,
  input  logic                 oe_n,
  input  logic                 order_lin,
  output logic [WORD_BITS-1:0] rdata,
  output logic                 rdata_oe
);
  logic cpu_take, ctl_take, load, sel_now;
  assign cpu_take = !ld_cpu_n && !cs_n;
  assign ctl_take = !ld_ctl_n;
  assign load     = cpu_take || ctl_take;
  assign sel_now  = !cs_n && cs_hi && !cs_lo_n;

  lane_mask_t dec_mask;
  lane_mask_t lane_n;
  assign lane_n = {wen_hi_n, wen_lo_n};

  sbsram_lane_dec u_dec (
    .rd_only    (cpu_take),
    .wen_all_n  (wen_all_n),
    .wen_gate_n (wen_gate_n),
    .lane_n     (lane_n),
    .mask       (dec_mask)
  );

  logic [ADDR_W-1:0]    base_q;
  logic                 sel_q;
  lane_mask_t           mask_q;
  logic [WORD_BITS-1:0] wdata_q;
  logic                 vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      sel_q   <= 1'b0;
      mask_q  <= '0;
      wdata_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      if (load) begin
        base_q <= addr;
        sel_q  <= sel_now;
      end
      mask_q  <= dec_mask;
      wdata_q <= wdata;
      vld_q   <= sel_q;
    end
  end

  logic [BEAT_W-1:0] cur_lo;

  sbsram_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .step   (!step_n && sel_q),
    .order  (order_e'(order_lin)),
    .start  (base_q[BEAT_W-1:0]),
    .cur_lo (cur_lo)
  );

  logic [ADDR_W-1:0] eff_addr;
  lane_mask_t        eff_mask;
  assign eff_addr = {base_q[ADDR_W-1:BEAT_W], cur_lo};
  assign eff_mask = sel_q ? mask_q : '0;

  sbsram_array #(.AW(ADDR_W), .LANE_W(LANE_BITS), .LANES(NUM_LANES)) u_arr (
    .clk   (clk),
    .addr  (eff_addr),
    .wmask (eff_mask),
    .wdata (wdata_q),
    .rd_q  (rdata)
  );

  assign rdata_oe = vld_q && !oe_n;

  a_r3_cpu_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_cpu_n && cs_n && ld_ctl_n) |=> ($stable(base_q) && $stable(sel_q)));
  a_r6_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (!wen_all_n && !cpu_take) |=> (mask_q == '1));
  a_r7_cpu_reads: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_take |=> (mask_q == '0));
  a_r9_deselect_lag: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |=> !vld_q);
endmodule

// File: tb/sim_sbsram_burst.sv
`timescale 1ns/1ps
module sim_sbsram_burst;
  localparam int AW = 6;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [AW-1:0] addr;
  logic [17:0] wdata, rdata;
  logic cs_n, cs_hi, cs_lo_n, ld_cpu_n, ld_ctl_n, step_n;
  logic wen_lo_n, wen_hi_n, wen_gate_n, wen_all_n, oe_n, order_lin, rdata_oe;

  sbsram_burst #(.ADDR_W(AW), .BEAT_W(2)) u0 (.*);

  int checks = 0, fails = 0;
  logic [17:0] shadow [N];

  function automatic logic [17:0] dgen(int a);
    return 18'(a * 7919 + 341);
  endfunction

  function automatic logic [1:0] lo_bits(logic [1:0] s, logic [1:0] b, logic lin);
    return lin ? 2'(s + b) : (s ^ b);
  endfunction

  task automatic chk(string tag, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ld_cpu_n = 1; ld_ctl_n = 1; step_n = 1;
    wen_lo_n = 1; wen_hi_n = 1; wen_gate_n = 1; wen_all_n = 1;
    cs_n = 0; cs_hi = 1; cs_lo_n = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; addr = '0; wdata = '0; oe_n = 0; order_lin = 1;
    idle();
    tick(); tick();
    chk("R9 reset oe", 18'(rdata_oe), 18'd0);
    rst_n = 1;
    tick();

    // R7 R8: fill with controller-strobe writes, pass-through checked one edge later
    for (int a = 0; a < N; a++) begin
      idle(); ld_ctl_n = 0; wen_all_n = 0; addr = AW'(a); wdata = dgen(a);
      tick();
      shadow[a] = dgen(a);
      if (a > 0) chk("R8 pass-through", rdata, dgen(a - 1));
    end
    idle(); tick();
    chk("R8 pass-through last", rdata, dgen(N - 1));
    chk("R1 oe high", 18'(rdata_oe), 18'd1);

    // R1 R2: back-to-back processor-strobe reads, write controls ignored (R7)
    for (int a = 0; a < N; a++) begin
      idle(); ld_cpu_n = 0; addr = AW'(a); wen_all_n = 0; wdata = 18'h3FFFF;
      tick();
      if (a > 0) chk("R1 read latency", rdata, shadow[a - 1]);
    end
    idle(); tick();
    chk("R1 read last", rdata, shadow[N - 1]);
    chk("R7 cpu load is read", rdata, dgen(N - 1));

    // R4 R5: read bursts, both orders, every start offset
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        order_lin = m[0];
        idle(); ld_ctl_n = 0; addr = AW'(16 + s);
        tick();
        for (int b = 0; b < 4; b++) begin
          idle(); step_n = (b < 3) ? 1'b0 : 1'b1;
          tick();
          chk(m ? "R5 linear beat" : "R5 interleaved beat", rdata,
              shadow[{2'b01, 2'b00, lo_bits(2'(s), 2'(b), m[0])}]);
        end
        idle(); tick();
        chk("R4 hold on step high", rdata,
            shadow[{2'b01, 2'b00, lo_bits(2'(s), 2'd3, m[0])}]);
      end
    end

    // R4 R5 R7: interleaved write burst from offset 2 at base 32, then read back
    order_lin = 0;
    idle(); ld_ctl_n = 0; addr = AW'(34); wen_all_n = 0; wdata = 18'h10000;
    tick();
    for (int b = 1; b < 4; b++) begin
      idle(); step_n = 0; wen_all_n = 0; wdata = 18'(18'h10000 + b);
      tick();
    end
    idle(); tick();
    for (int b = 0; b < 4; b++) shadow[32 + int'(2'd2 ^ 2'(b))] = 18'(18'h10000 + b);
    for (int a = 32; a < 36; a++) begin
      idle(); ld_cpu_n = 0; addr = AW'(a);
      tick(); idle(); tick();
      chk("R7 burst write readback", rdata, shadow[a]);
    end

    // R6 R8: all sixteen write-control combinations
    order_lin = 1;
    for (int c = 0; c < 16; c++) begin
      logic [17:0] pat, expw;
      logic ml, mh;
      pat = 18'h2A5A5 ^ 18'(c * 4097);
      ml = !c[3] || (!c[2] && !c[0]);
      mh = !c[3] || (!c[2] && !c[1]);
      expw = {mh ? pat[17:9] : shadow[c][17:9], ml ? pat[8:0] : shadow[c][8:0]};
      idle(); ld_ctl_n = 0; addr = AW'(c); wdata = pat;
      wen_all_n = c[3]; wen_gate_n = c[2]; wen_hi_n = c[1]; wen_lo_n = c[0];
      tick(); idle(); tick();
      chk("R6 lane merge pass-through", rdata, expw);
      shadow[c] = expw;
    end
    for (int c = 0; c < 16; c++) begin
      idle(); ld_cpu_n = 0; addr = AW'(c);
      tick(); idle(); tick();
      chk("R6 lane readback", rdata, shadow[c]);
    end

    // R3: processor strobe with cs_n high is ignored
    idle(); ld_cpu_n = 0; addr = AW'(5); tick();
    idle(); ld_cpu_n = 0; cs_n = 1; addr = AW'(9); tick();
    idle(); tick();
    chk("R3 address kept", rdata, shadow[5]);
    chk("R3 still selected", 18'(rdata_oe), 18'd1);

    // R2 R9: controller strobe honoured with cs_n high, deselects after two edges
    idle(); ld_ctl_n = 0; cs_n = 1; addr = AW'(7); tick();
    chk("R9 oe held one edge", 18'(rdata_oe), 18'd1);
    idle(); tick();
    chk("R9 deselected cs_n", 18'(rdata_oe), 18'd0);
    idle(); ld_ctl_n = 0; addr = AW'(7); tick(); idle(); tick();
    chk("R2 reselect read", rdata, shadow[7]);
    idle(); ld_ctl_n = 0; cs_hi = 0; tick(); idle(); tick();
    chk("R9 deselected cs_hi", 18'(rdata_oe), 18'd0);
    idle(); ld_cpu_n = 0; cs_lo_n = 1; addr = AW'(3); tick(); idle(); tick();
    chk("R9 deselected cs_lo_n", 18'(rdata_oe), 18'd0);
    idle(); ld_cpu_n = 0; addr = AW'(3); tick(); idle(); tick();
    chk("R9 reselected", 18'(rdata_oe), 18'd1);

    // R10: asynchronous output enable
    oe_n = 1; #1;
    chk("R10 oe_n high", 18'(rdata_oe), 18'd0);
    oe_n = 0; #1;
    chk("R10 oe_n low", 18'(rdata_oe), 18'd1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule